// File: doc/BRIEF.md
# Dual-Rail Power-Up Sequencer

This block switches on the two supplies of a display panel in a fixed order and watches them while they come up. A digital logic rail is enabled first. The analog rail is enabled only after the digital rail reports power-good. The analog rail is watched by two threshold comparators, one low and one high, and its rise time between them must fall inside a window. The time is taken from a free-running tick strobe that the surrounding chip supplies (10 µs per tick in the default configuration).

Any violation latches a fault code and starts an orderly shutdown. The analog enable drops at once, and the digital enable drops only after a discharge delay. A stop request uses the same reverse order without a fault. The comparator and power-good inputs are asynchronous and pass through a synchroniser of `SYNC_STAGES` flops. The run request and the tick are synchronous inputs.

Default limits, in ticks: `DIG_MAX_TICKS` = 5000, `ANA_MIN_TICKS` = 50, `ANA_MAX_TICKS` = 5000, `DISCHARGE_TICKS` = 100.

Top module: `pwrseq_dual_rail`

## Requirements
- R1: `ana_en` is never high while `dig_en` is low. `ana_en` rises only after `dig_good` has been seen high, and while `dig_good` stays low the analog rail stays off.
- R2: Out of reset all outputs are low and `fault_code` is 0. With `run` high in the idle state, `dig_en` goes high on the next clock edge while `ana_en` stays low.
- R3: Suppose `dig_good` is not seen within `DIG_MAX_TICKS` ticks of `dig_en` rising. Then `fault` rises `DIG_MAX_TICKS`+1 cycles after `dig_en` when `tick` is held high, and `fault_code` becomes 1 (digital too slow).
- R4: The analog rise is measured as the number of ticks from the cycle where `ana_lo` is first seen up to, but not including, the cycle where `ana_hi` is seen. A rise shorter than `ANA_MIN_TICKS` gives `fault_code` 2 (analog too fast). The same code is given when `ana_hi` is seen without a prior or simultaneous `ana_lo`.
- R5: A rise longer than `ANA_MAX_TICKS` gives `fault_code` 3 (analog timeout). If `ana_lo` never appears, the fault is raised `ANA_MAX_TICKS`+1 cycles after `ana_en` rises when `tick` is held high.
- R6: A rise from `ANA_MIN_TICKS` to `ANA_MAX_TICKS` ticks inclusive sets `ready`, with both enables high and no fault.
- R7: If the synchronised `dig_good` drops while `ready` is high, `ana_en` falls and `fault` rises on the next edge, with `fault_code` 4 (digital lost).
- R8: On any fault, `ana_en` is off on entry. `dig_en` falls `DISCHARGE_TICKS`+1 cycles later with `tick` held high. The fault and its code stay latched while `run` is high. Dropping `run` after the discharge returns the block to idle with `fault_code` 0, and a new start is possible.
- R9: Dropping `run` while powered switches `ana_en` off first. `dig_en` then follows `DISCHARGE_TICKS`+1 cycles later with `tick` held high, and no fault is raised.
- R10: All time limits advance only on cycles where `tick` is high. With `tick` held low, no timeout ever fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe, one cycle per tick |
| run | input | 1 | Power-up request (level); low requests shutdown |
| dig_good | input | 1 | Digital rail power-good (asynchronous) |
| ana_lo | input | 1 | Analog rail above low threshold (asynchronous) |
| ana_hi | input | 1 | Analog rail above high threshold (asynchronous) |
| dig_en | output | 1 | Digital rail enable |
| ana_en | output | 1 | Analog rail enable |
| ready | output | 1 | Both rails up and within limits |
| fault | output | 1 | Fault latched |
| fault_code | output | 3 | 0 none, 1 digital slow, 2 analog fast, 3 analog timeout, 4 digital lost |

## Verification
Some properties are checked on every cycle: the rail ordering, the rule that the digital enable only drops once the analog one is already off, the prompt analog shutdown after a loss of digital power-good, and the agreement between the fault flag and its code. Only the bench scenarios can show the timing windows. They sweep the digital power-good delay and the analog rise length across both sides of each limit. They measure the exact cycle gaps of the timeouts and of the discharge delay. They also show that faults stay latched, that a frozen timebase stops all timing, and that the block restarts after a fault.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_DRAMP,
        ST_ARAMP,
        ST_ON,
        ST_DOWN,
        ST_FAULT
    } seq_state_e;

    localparam int FC_W = 3;

    typedef enum logic [FC_W-1:0] {
        FC_NONE     = 3'd0,
        FC_DIG_SLOW = 3'd1,
        FC_ANA_FAST = 3'd2,
        FC_ANA_SLOW = 3'd3,
        FC_DIG_LOST = 3'd4
    } fault_code_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/seq_input_sync.sv
module seq_input_sync #(
    parameter int STAGES = 2,
    parameter int W      = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    generate
        if (STAGES == 0) begin : g_bypass
            assign d_out = d_in;
        end else begin : g_chain
            logic [STAGES-1:0][W-1:0] chain_q;
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain_q <= '0;
                end else begin
                    chain_q[0] <= d_in;
                    for (int i = 1; i < STAGES; i++) begin
                        chain_q[i] <= chain_q[i-1];
                    end
                end
            end
            assign d_out = chain_q[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/seq_tick_counter.sv
module seq_tick_counter #(
    parameter int W = 13
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = clr ? '0 : cnt_q;
        if (tick && (cnt_d != '1)) begin
            cnt_d = cnt_d + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/seq_ctrl_fsm.sv
module seq_ctrl_fsm
    import pwrseq_pkg::*;
#(
    parameter int CNT_W     = 13,
    parameter int DIG_MAX   = 5000,
    parameter int ANA_MIN   = 50,
    parameter int ANA_MAX   = 5000,
    parameter int DISCHARGE = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             dig_good,
    input  logic             ana_lo,
    input  logic             ana_hi,
    input  logic [CNT_W-1:0] cnt,
    output logic             cnt_clr,
    output logic             dig_en,
    output logic             ana_en,
    output logic             ready,
    output logic             fault,
    output logic [FC_W-1:0]  fault_code
);
    localparam logic [CNT_W-1:0] DIG_LIM = CNT_W'(DIG_MAX);
    localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(ANA_MIN);
    localparam logic [CNT_W-1:0] ANA_LIM = CNT_W'(ANA_MAX);
    localparam logic [CNT_W-1:0] DIS_LIM = CNT_W'(DISCHARGE);

    typedef struct packed {
        seq_state_e  st;
        logic        lo_seen;
        logic        dis_done;
        fault_code_e code;
    } fsm_t;

    fsm_t r_d, r_q;
    logic clr_d;

    always_comb begin
        r_d   = r_q;
        clr_d = 1'b0;
        unique case (r_q.st)
            ST_OFF: begin
                r_d.code     = FC_NONE;
                r_d.dis_done = 1'b0;
                if (run) begin
                    r_d.st = ST_DRAMP;
                    clr_d  = 1'b1;
                end
            end
            ST_DRAMP: begin
                if (dig_good && run) begin
                    r_d.st      = ST_ARAMP;
                    r_d.lo_seen = 1'b0;
                    clr_d       = 1'b1;
                end else if (!dig_good && (cnt > DIG_LIM)) begin
                    r_d.st       = ST_FAULT;
                    r_d.code     = FC_DIG_SLOW;
                    r_d.dis_done = 1'b0;
                    clr_d        = 1'b1;
                end else if (!run) begin
                    r_d.st = ST_DOWN;
                    clr_d  = 1'b1;
                end
            end
            ST_ARAMP: begin
                if (!dig_good) begin
                    r_d.st       = ST_FAULT;
                    r_d.code     = FC_DIG_LOST;
                    r_d.dis_done = 1'b0;
                    clr_d        = 1'b1;
                end else if (cnt > ANA_LIM) begin
                    r_d.st       = ST_FAULT;
                    r_d.code     = FC_ANA_SLOW;
                    r_d.dis_done = 1'b0;
                    clr_d        = 1'b1;
                end else if (ana_hi) begin
                    if (!r_q.lo_seen || (cnt < MIN_LIM)) begin
                        r_d.st       = ST_FAULT;
                        r_d.code     = FC_ANA_FAST;
                        r_d.dis_done = 1'b0;
                        clr_d        = 1'b1;
                    end else begin
                        r_d.st = ST_ON;
                    end
                end else if (!run) begin
                    r_d.st = ST_DOWN;
                    clr_d  = 1'b1;
                end else if (ana_lo && !r_q.lo_seen) begin
                    r_d.lo_seen = 1'b1;
                    clr_d       = 1'b1;
                end
            end
            ST_ON: begin
                if (!dig_good) begin
                    r_d.st       = ST_FAULT;
                    r_d.code     = FC_DIG_LOST;
                    r_d.dis_done = 1'b0;
                    clr_d        = 1'b1;
                end else if (!run) begin
                    r_d.st = ST_DOWN;
                    clr_d  = 1'b1;
                end
            end
            ST_DOWN: begin
                if (cnt > DIS_LIM) begin
                    r_d.st = ST_OFF;
                end
            end
            ST_FAULT: begin
                if (!r_q.dis_done && (cnt > DIS_LIM)) begin
                    r_d.dis_done = 1'b1;
                end
                if (r_q.dis_done && !run) begin
                    r_d.st   = ST_OFF;
                    r_d.code = FC_NONE;
                end
            end
            default: begin
                r_d.st = ST_OFF;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_OFF, lo_seen: 1'b0, dis_done: 1'b0, code: FC_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    assign cnt_clr    = clr_d;
    assign dig_en     = (r_q.st inside {ST_DRAMP, ST_ARAMP, ST_ON, ST_DOWN}) ||
                        ((r_q.st == ST_FAULT) && !r_q.dis_done);
    assign ana_en     = (r_q.st inside {ST_ARAMP, ST_ON});
    assign ready      = (r_q.st == ST_ON);
    assign fault      = (r_q.st == ST_FAULT);
    assign fault_code = r_q.code;
endmodule

// File: rtl/pwrseq_dual_rail.sv
module pwrseq_dual_rail
    import pwrseq_pkg::*;
#(
    parameter int DIG_MAX_TICKS   = 5000,
    parameter int ANA_MIN_TICKS   = 50,
    parameter int ANA_MAX_TICKS   = 5000,
    parameter int DISCHARGE_TICKS = 100,
    parameter int SYNC_STAGES     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            run,
    input  logic            dig_good,
    input  logic            ana_lo,
    input  logic            ana_hi,
    output logic            dig_en,
    output logic            ana_en,
    output logic            ready,
    output logic            fault,
    output logic [FC_W-1:0] fault_code
);
    localparam int LIM_MAX = max3(DIG_MAX_TICKS, ANA_MAX_TICKS, DISCHARGE_TICKS);
    localparam int CNT_W   = $clog2(LIM_MAX + 2);

    logic [2:0]       raw_in, sync_out;
    logic             dig_good_s, ana_lo_s, ana_hi_s;
    logic             cnt_clr;
    logic [CNT_W-1:0] cnt;

    assign raw_in = {dig_good, ana_lo, ana_hi};
    assign {dig_good_s, ana_lo_s, ana_hi_s} = sync_out;

    seq_input_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (raw_in),
        .d_out (sync_out)
    );

    seq_tick_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .tick  (tick),
        .count (cnt)
    );

    seq_ctrl_fsm #(
        .CNT_W     (CNT_W),
        .DIG_MAX   (DIG_MAX_TICKS),
        .ANA_MIN   (ANA_MIN_TICKS),
        .ANA_MAX   (ANA_MAX_TICKS),
        .DISCHARGE (DISCHARGE_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .dig_good   (dig_good_s),
        .ana_lo     (ana_lo_s),
        .ana_hi     (ana_hi_s),
        .cnt        (cnt),
        .cnt_clr    (cnt_clr),
        .dig_en     (dig_en),
        .ana_en     (ana_en),
        .ready      (ready),
        .fault      (fault),
        .fault_code (fault_code)
    );
endmodule

// File: rtl/pwrseq_checker.sv
module pwrseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       dig_en,
    input logic       ana_en,
    input logic       ready,
    input logic       fault,
    input logic [2:0] fault_code,
    input logic       dig_good_s
);
    // R1: analog rail only while the digital rail is on
    p_order_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ana_en |-> dig_en);

    // R1: analog enable rises only after the digital rail was already on
    p_rise_after_dig_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ana_en) |-> $past(dig_en));

    // R7: loss of digital power-good while ready shuts the analog rail next cycle
    p_dig_lost_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !dig_good_s) |=> (fault && !ana_en && fault_code == 3'd4));

    // R8: a fault always carries a nonzero code
    p_fault_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (fault_code != 3'd0));

    // R8: no code without a fault
    p_no_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> (fault_code == 3'd0));

    // R9: digital rail drops only once the analog rail is already off
    p_vcc_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dig_en) |-> (!ana_en && $past(!ana_en)));
endmodule

bind pwrseq_dual_rail pwrseq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dig_en     (dig_en),
    .ana_en     (ana_en),
    .ready      (ready),
    .fault      (fault),
    .fault_code (fault_code),
    .dig_good_s (dig_good_s)
);

// File: tb/sim_pwrseq_dual_rail.sv
module sim_pwrseq_dual_rail;
    localparam int DMAX = 8;
    localparam int AMIN = 3;
    localparam int AMAX = 8;
    localparam int DIS  = 4;
    localparam int S    = 2;

    logic clk = 1'b0;
    logic rst_n, tick, run, dig_good, ana_lo, ana_hi;
    logic dig_en, ana_en, ready, fault;
    logic [2:0] fault_code;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    pwrseq_dual_rail #(
        .DIG_MAX_TICKS(DMAX), .ANA_MIN_TICKS(AMIN), .ANA_MAX_TICKS(AMAX),
        .DISCHARGE_TICKS(DIS), .SYNC_STAGES(S)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .run(run),
        .dig_good(dig_good), .ana_lo(ana_lo), .ana_hi(ana_hi),
        .dig_en(dig_en), .ana_en(ana_en), .ready(ready),
        .fault(fault), .fault_code(fault_code)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic shutdown();
        run = 1'b0; dig_good = 1'b0; ana_lo = 1'b0; ana_hi = 1'b0;
        repeat (DIS + S + 8) @(negedge clk);
        chk("R8 idle after shutdown", {dig_en, ana_en, fault}, 0);
        chk("R8 code cleared", fault_code, 0);
    endtask

    task automatic start_rail();
        run = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ana();
        for (int n = 0; n < 40 && !ana_en && !fault; n++) @(negedge clk);
    endtask

    task automatic bring_ready();
        start_rail();
        dig_good = 1'b1;
        wait_ana();
        ana_lo = 1'b1;
        repeat (AMIN + 1) @(negedge clk);
        ana_hi = 1'b1;
        for (int n = 0; n < 20 && !ready; n++) @(negedge clk);
        chk("R6 ready reached", ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        rst_n = 1'b0; tick = 1'b1; run = 1'b0;
        dig_good = 1'b0; ana_lo = 1'b0; ana_hi = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state
        chk("R2 reset outputs", {dig_en, ana_en, ready, fault}, 0);
        chk("R2 reset code", fault_code, 0);

        // R2 start, R10 frozen timebase, R1 no analog without good
        tick = 1'b0;
        start_rail();
        chk("R2 dig_en after run", dig_en, 1);
        chk("R2 ana_en stays off", ana_en, 0);
        repeat (60) @(negedge clk);
        chk("R10 no timeout without ticks", fault, 0);
        chk("R1 analog held off without dig_good", ana_en, 0);
        tick = 1'b1;
        for (int i = 0; i < 40 && !fault; i++) @(negedge clk);
        chk("R3 timeout once ticking", fault_code, 1);
        shutdown();

        // R3 exact digital timeout, R8 discharge and latch
        start_rail();
        n = 0;
        while (!fault && n < 100) begin @(negedge clk); n++; end
        chk("R3 digital timeout gap", n, DMAX + 1);
        chk("R3 code digital slow", fault_code, 1);
        n = 0;
        while (dig_en && n < 100) begin @(negedge clk); n++; end
        chk("R8 discharge gap", n, DIS + 1);
        repeat (10) @(negedge clk);
        chk("R8 fault latched", fault, 1);
        chk("R8 code latched", fault_code, 1);
        chk("R8 dig off in fault", dig_en, 0);
        run = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 clear on run low", fault, 0);
        chk("R8 code clear", fault_code, 0);
        start_rail();
        chk("R8 restart after fault", dig_en, 1);
        shutdown();

        // R3/R1 sweep of digital power-good delay
        for (int k = 0; k <= DMAX - S + 2; k++) begin
            bit ok;
            ok = (k + S) <= DMAX;
            start_rail();
            repeat (k) @(negedge clk);
            dig_good = 1'b1;
            wait_ana();
            chk($sformatf("R1 ana_en after good delay %0d", k), ana_en, ok ? 1 : 0);
            chk($sformatf("R3 code for good delay %0d", k), fault_code, ok ? 0 : 1);
            shutdown();
        end

        // R4/R5/R6 sweep of analog rise length
        for (int j = 0; j <= AMAX + 2; j++) begin
            int ec;
            ec = (j < AMIN) ? 2 : ((j <= AMAX) ? 0 : 3);
            start_rail();
            dig_good = 1'b1;
            wait_ana();
            ana_lo = 1'b1;
            repeat (j) @(negedge clk);
            ana_hi = 1'b1;
            repeat (S + 2) @(negedge clk);
            chk($sformatf("R4 R5 R6 code for rise %0d", j), fault_code, ec);
            chk($sformatf("R6 ready for rise %0d", j), ready, (ec == 0) ? 1 : 0);
            shutdown();
        end

        // R4 high threshold without low threshold
        start_rail();
        dig_good = 1'b1;
        wait_ana();
        ana_hi = 1'b1;
        repeat (S + 2) @(negedge clk);
        chk("R4 high without low is too fast", fault_code, 2);
        shutdown();

        // R5 exact analog timeout, R8 reverse order
        start_rail();
        dig_good = 1'b1;
        wait_ana();
        n = 0;
        while (!fault && n < 100) begin @(negedge clk); n++; end
        chk("R5 analog timeout gap", n, AMAX + 1);
        chk("R5 code analog timeout", fault_code, 3);
        chk("R8 analog off on fault", ana_en, 0);
        n = 0;
        while (dig_en && n < 100) begin @(negedge clk); n++; end
        chk("R8 discharge gap after analog fault", n, DIS + 1);
        shutdown();

        // R9 orderly stop
        bring_ready();
        run = 1'b0;
        @(negedge clk);
        chk("R9 analog off first", ana_en, 0);
        chk("R9 digital still on", dig_en, 1);
        n = 0;
        while (dig_en && n < 100) begin @(negedge clk); n++; end
        chk("R9 stop discharge gap", n, DIS + 1);
        chk("R9 no fault on stop", fault, 0);
        shutdown();

        // R7 digital lost while ready
        bring_ready();
        dig_good = 1'b0;
        repeat (S) @(negedge clk);
        chk("R7 analog on before loss seen", ana_en, 1);
        @(negedge clk);
        chk("R7 analog off after loss", ana_en, 0);
        chk("R7 fault raised", fault, 1);
        chk("R7 code digital lost", fault_code, 4);
        shutdown();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule